// File: doc/BRIEF.md
# Partitioned SIMD Lane Slice Extractor

This block takes a 64-bit packed SIMD word and a lane-width select, and pulls the same fixed bit range out of every active lane. The range, from a low bound up to but not including a high bound, is set by parameters at elaboration. Each extracted field is exactly as wide as the range, whatever the lane width. A 3:6 slice therefore gives 3-bit fields whether the lanes are 8, 16, 32 or 64 bits wide.

The fields land in a narrow output built from eight equal slots, each as wide as the slice. With 8-bit lanes every slot is filled. With wider lanes each result stays in the slot that matches the lowest byte of its lane. The slots between results are padding and are driven to zero. An 8-bit valid mask marks which slots hold real elements, so downstream logic can tell data from padding.

The datapath is combinational. An optional output register, on by default, adds one cycle of latency and clears on a synchronous reset.

Top module: `lane_slice`

## Requirements
- R1: The data output is 8×W bits, where W = SLICE_HI − SLICE_LO. Slot k takes bits [k·W + W−1 : k·W].
- R2: When `ew_sel` = 2'b11 (8-bit lanes), slot k holds `din[8k+SLICE_HI−1 : 8k+SLICE_LO]` for every k from 0 to 7.
- R3: When `ew_sel` = 2'b10 (16-bit lanes), lane j's slice `din[16j+SLICE_HI−1 : 16j+SLICE_LO]` goes to slot 2j. Slots 1, 3, 5 and 7 are padding.
- R4: When `ew_sel` = 2'b01 (32-bit lanes), lane 0's slice goes to slot 0 and lane 1's slice (`din[32+SLICE_HI−1 : 32+SLICE_LO]`) goes to slot 4. All other slots are padding.
- R5: When `ew_sel` = 2'b00 (one 64-bit lane), slot 0 holds `din[SLICE_HI−1 : SLICE_LO]` and slots 1 to 7 are padding.
- R6: Every padding slot reads all zeros, whatever the bits of `din` that lie outside the active slices.
- R7: `slot_vld` bit k is 1 exactly when slot k holds a real element. The mask is 8'hFF for 8-bit lanes, 8'h55 for 16-bit lanes, 8'h11 for 32-bit lanes and 8'h01 for one 64-bit lane.
- R8: With REG_OUT = 1, both outputs reflect the inputs sampled at the previous rising clock edge. A high `rst` at an edge sets both outputs to zero.
- R9: A change of `ew_sel` takes effect on the very next output update, with no settling cycles, even when `din` stays constant.
- R10: Elaboration fails when SLICE_HI ≤ SLICE_LO or SLICE_HI > 8, because the slice must fit inside the narrowest lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| ew_sel | input | 2 | Lane width: 00 = 64, 01 = 32, 10 = 16, 11 = 8 bits |
| din | input | 64 | Packed SIMD input word |
| dout | output | 8×(SLICE_HI−SLICE_LO) | Slot-packed slices, with zero padding |
| slot_vld | output | 8 | One bit per slot, set when the slot holds an element |

## Verification
The hardest case to reach is a padding slot whose source byte is full of ones. Only then does a slot that failed to blank show up as a wrong value. Random words rarely line up with the right mode for this, so directed all-ones words are applied in every wide-lane mode, each followed by a back-to-back mode change on the same word. Random phases then cover the lane mapping, using a fresh word and a fresh mode on every cycle.

// File: rtl/lane_slice_pkg.sv
package lane_slice_pkg;

  localparam int NUM_SLOTS = 8;

  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } ew_e;

  // log2 of the slot spacing between consecutive real elements
  function automatic int unsigned stride_log2(input ew_e ew);
    case (ew)
      EW_8:    return 0;
      EW_16:   return 1;
      EW_32:   return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/lane_slice_mask.sv
module lane_slice_mask
  import lane_slice_pkg::*;
(
  input  ew_e                  ew,
  output logic [NUM_SLOTS-1:0] vld
);

  // A slot is live when its index is a multiple of the lane size in bytes
  always_comb begin
    int unsigned sl;
    sl = stride_log2(ew);
    for (int k = 0; k < NUM_SLOTS; k++) begin
      vld[k] = ((k & ((1 << sl) - 1)) == 0);
    end
  end

endmodule

// File: rtl/lane_slice_field.sv
module lane_slice_field #(
  parameter int UNIT_W = 8,
  parameter int LO     = 3,
  parameter int HI     = 6,
  localparam int W     = HI - LO
) (
  input  logic [UNIT_W-1:0] unit_in,
  input  logic              en,
  output logic [W-1:0]      field
);

  // Padding slots are forced to zero
  always_comb begin
    field = en ? unit_in[HI-1:LO] : '0;
  end

endmodule

// File: rtl/lane_slice.sv
module lane_slice
  import lane_slice_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SLICE_LO = 3,
  parameter int SLICE_HI = 6,
  parameter bit REG_OUT  = 1'b1,
  localparam int W       = SLICE_HI - SLICE_LO,
  localparam int OUT_W   = NUM_SLOTS * W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           ew_sel,
  input  logic [DATA_W-1:0]    din,
  output logic [OUT_W-1:0]     dout,
  output logic [NUM_SLOTS-1:0] slot_vld
);

  localparam int UNIT_W = DATA_W / NUM_SLOTS;

  // Elaboration checks on the slice bounds
  generate
    if (SLICE_HI <= SLICE_LO) begin : g_bad_order
      $error("lane_slice: SLICE_HI must exceed SLICE_LO");    // R10
    end
    if (SLICE_HI > UNIT_W || SLICE_HI > 8) begin : g_bad_fit
      $error("lane_slice: slice exceeds the narrowest lane"); // R10
    end
    if (DATA_W != 64) begin : g_bad_width
      $error("lane_slice: DATA_W must be 64");
    end
  endgenerate

  ew_e                  ew;
  logic [NUM_SLOTS-1:0] vld_c;
  logic [OUT_W-1:0]     dat_c;

  assign ew = ew_e'(ew_sel);

  lane_slice_mask u_mask (
    .ew  (ew),
    .vld (vld_c)
  );

  // Each lane starts at the byte whose slot receives its result, so slot k
  // always draws from input unit k.
  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      lane_slice_field #(
        .UNIT_W (UNIT_W),
        .LO     (SLICE_LO),
        .HI     (SLICE_HI)
      ) u_field (
        .unit_in (din[k*UNIT_W +: UNIT_W]),
        .en      (vld_c[k]),
        .field   (dat_c[k*W +: W])
      );
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_reg
      logic primed;

      always_ff @(posedge clk) begin
        if (rst) begin
          dout     <= '0;
          slot_vld <= '0;
          primed   <= 1'b0;
        end else begin
          dout     <= dat_c;
          slot_vld <= vld_c;
          primed   <= 1'b1;
        end
      end

      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
          !slot_vld[k] |-> (dout[k*W +: W] == '0)); // R6
      end

      AST_MASK_COUNT: assert property (@(posedge clk) disable iff (rst)
        primed |-> ($countones(slot_vld) == (8 >> stride_log2(ew_e'($past(ew_sel)))))); // R7
      AST_SLOT0_LIVE: assert property (@(posedge clk) disable iff (rst)
        primed |-> slot_vld[0]); // R5
      AST_DENSE_BYTES: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(ew_sel) == 2'b11) |-> (slot_vld == 8'hFF)); // R2
      AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (dout == '0 && slot_vld == '0)); // R8
    end else begin : g_comb
      assign dout     = dat_c;
      assign slot_vld = vld_c;

      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
          !slot_vld[k] |-> (dout[k*W +: W] == '0)); // R6
      end

      AST_MASK_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_vld) == (8 >> stride_log2(ew))); // R7
      AST_SLOT0_LIVE: assert property (@(posedge clk) disable iff (rst)
        slot_vld[0]); // R5
    end
  endgenerate

endmodule

// File: tb/lane_slice_bench.sv
`timescale 1ns/1ps
module lane_slice_bench;

  localparam int LO    = 3;
  localparam int HI    = 6;
  localparam int W     = HI - LO;
  localparam int OUT_W = 8 * W;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       ew_sel;
  logic [63:0]      din;
  logic [OUT_W-1:0] dout;
  logic [7:0]       slot_vld;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  lane_slice #(.DATA_W(64), .SLICE_LO(LO), .SLICE_HI(HI), .REG_OUT(1'b1)) u_lane_slice (
    .clk      (clk),
    .rst      (rst),
    .ew_sel   (ew_sel),
    .din      (din),
    .dout     (dout),
    .slot_vld (slot_vld)
  );

  // Lane-oriented model: lane count from the mode, each lane sliced,
  // its result placed at slot lane*(8/lanes).
  function automatic int lanes_of(input logic [1:0] m);
    case (m)
      2'b11:   return 8;
      2'b10:   return 4;
      2'b01:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] exp_data(input logic [1:0] m, input logic [63:0] d);
    logic [OUT_W-1:0] r;
    int nl, lw, sp;
    logic [63:0] sh;
    r  = '0;
    nl = lanes_of(m);
    lw = 64 / nl;
    sp = 8 / nl;
    for (int j = 0; j < nl; j++) begin
      sh = d >> (j * lw + LO);
      r[(j*sp)*W +: W] = sh[W-1:0];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_mask(input logic [1:0] m);
    logic [7:0] r;
    int nl;
    r  = '0;
    nl = lanes_of(m);
    for (int j = 0; j < nl; j++) r[j * (8 / nl)] = 1'b1;
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b11:   return "R2";
      2'b10:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] ed, input logic [7:0] em);
    tests++;
    if (dout !== ed || slot_vld !== em) begin
      fails++;
      $display("FAIL %s: dout=%h vld=%h expected dout=%h vld=%h", req, dout, slot_vld, ed, em);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check.
  task automatic apply(input string req, input logic [1:0] m, input logic [63:0] d);
    ew_sel = m;
    din    = d;
    @(negedge clk);
    check(req, exp_data(m, d), exp_mask(m));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst    = 1'b1;
    ew_sel = 2'b11;
    din    = '1;
    repeat (3) @(negedge clk);
    check("R8 reset", '0, '0);
    rst = 1'b0;

    // R1/R2: walking patterns in dense mode locate each slot
    apply("R1 R2", 2'b11, 64'h0102_0408_1020_4080);
    apply("R2", 2'b11, 64'h3838_3838_3838_3838);
    // R6: all-ones in every wide mode, padding must stay zero
    apply("R6 R3", 2'b10, '1);
    apply("R6 R4", 2'b01, '1);
    apply("R6 R5", 2'b00, '1);
    // R9: mode flips on an unchanged word
    apply("R9", 2'b11, '1);
    apply("R9", 2'b00, '1);
    apply("R9 R4", 2'b01, 64'h0000_0028_0000_0010);
    apply("R3", 2'b10, 64'h0038_0000_0028_0010);
    apply("R7", 2'b10, '0);

    // R8: reset in mid-stream clears outputs
    ew_sel = 2'b11;
    din    = '1;
    rst    = 1'b1;
    @(negedge clk);
    check("R8 sync reset", '0, '0);
    rst = 1'b0;

    for (int i = 0; i < 2000; i++) begin
      logic [1:0]  m;
      logic [63:0] d;
      m = 2'($urandom_range(0, 3));
      d = {$urandom, $urandom};
      apply(req_of(m), m, d);
    end
    finish_run();
  end

endmodule